// File: doc/BRIEF.md
# Index-Prefix Instruction Decoder

This block turns the bytes of an index-prefixed instruction for an 8-bit accumulator machine into one decoded operation record. Bytes arrive one per accepted transfer on a valid/ready stream, starting with the prefix byte. The prefix picks one of two 16-bit index registers. The byte after it is the opcode. The decoder then collects any signed displacement and any 8-bit or 16-bit immediate the opcode needs, and emits a one-cycle record. The record gives the operation class, a destination selector, a source selector, the sign-extended displacement, the immediate value and the total instruction length.

The supported rows are the ones where the usual HL slot is redirected: to the selected index register, to one of its 8-bit halves, or to memory at index plus displacement. These are the 16-bit add, the 16-bit immediate load, the absolute-address transfers, the 16-bit and 8-bit increment and decrement, and the 8-bit immediate loads. A 0xCB byte after the prefix is not decoded here. The block closes the instruction with a hand-off record, and a separate bit-operation decoder consumes the bytes that follow. Any other opcode yields a no-operation record.

Top module: `idx_prefix_decoder`

## Requirements
- R1: At the start of an instruction, byte 0xDD selects index register 0 (out_idx=0) and byte 0xFD selects index register 1 (out_idx=1). Any other byte at that point is consumed, produces no record, and leaves the decoder waiting for a prefix.
- R2: Opcode 0xCB after a prefix yields op class 10 (bit-operation hand-off) with length 2 and both selectors 0. The next byte is treated as the start of a new instruction.
- R3: Opcodes 0x09, 0x19, 0x29 and 0x39 yield op class 1 (16-bit add), with destination 4 (index register) and length 2. The source is taken from opcode bits 5:4: 0 gives 1 (BC), 1 gives 2 (DE), 2 gives 4 (the index register) and 3 gives 3 (SP).
- R4: Opcode 0x21 yields op class 2, destination 4 and source 10 (16-bit immediate), with length 4. out_imm is {second byte, first byte} of the two bytes after the opcode.
- R5: Opcode 0x22 yields op class 3 (store index to address), destination 8 (absolute memory) and source 4. Opcode 0x2A yields op class 4, destination 4 and source 8. Both take a little-endian address in out_imm and have length 4.
- R6: Opcode 0x23 yields op class 5 (16-bit increment) and 0x2B yields op class 6 (16-bit decrement). Both have destination 4, source 0 and length 2.
- R7: Opcodes 0x24/0x2C yield op class 7 (8-bit increment) and 0x25/0x2D yield op class 8 (8-bit decrement), both with length 2. Opcodes 0x26/0x2E yield op class 9 (8-bit immediate load) with source 9, out_imm = {0x00, immediate} and length 3. Opcode bit 3 clear selects destination 5 (high half); bit 3 set selects 6 (low half).
- R8: Opcodes 0x34, 0x35 and 0x36 use destination 7 (memory at index plus displacement). The displacement byte follows the opcode and appears on out_disp sign-extended to 16 bits. 0x34 yields op class 7 and 0x35 yields op class 8, both with length 3. 0x36 yields op class 9 with source 9, length 4, and the immediate byte after the displacement.
- R9: Every other opcode after a prefix yields op class 0 (no-operation) with both selectors 0 and length 2.
- R10: out_disp is 0 in every record whose destination is not 7. out_imm is 0 in every record that takes no immediate.
- R11: out_valid is high for exactly one cycle, the cycle after the final byte of the instruction is accepted. The record fields hold their values until the next record.
- R12: While reset is asserted, in_ready and out_valid are low and the record fields are 0. From the first clock after reset is released, in_ready is high.
- R13: out_len equals the number of bytes consumed by the instruction, counting the prefix.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Instruction byte is offered |
| in_byte | input | 8 | Instruction byte |
| in_ready | output | 1 | Decoder accepts a byte this cycle |
| out_valid | output | 1 | One-cycle pulse: record is complete |
| out_idx | output | 1 | Selected index register (0 or 1) |
| out_op | output | 4 | Operation class |
| out_dst | output | 4 | Destination selector |
| out_src | output | 4 | Source selector |
| out_disp | output | 16 | Sign-extended displacement |
| out_imm | output | 16 | Immediate byte or word |
| out_len | output | 3 | Instruction length in bytes |

## Verification
The hardest case to reach from the ports is the longest path through the sequencer. In the displacement-then-immediate form (prefix, 0x36, displacement, immediate), the final byte must be placed in the immediate field while the earlier, saved displacement is sign-extended. The stimulus feeds that form with negative displacements, back to back with other instructions. It follows it with a form that takes neither field, which shows that stale displacement and immediate values are cleared. Stray bytes between instructions and a hand-off record followed at once by a new prefix check that the decoder returns cleanly to its waiting state.

// File: rtl/idx_dec_pkg.sv
// Shared types for the index-prefix decoder.
// Assumes an 8-bit instruction byte and a 16-bit address space.
package idx_dec_pkg;
    localparam int BYTE_W = 8;
    localparam int WORD_W = 16;
    localparam int LEN_W  = 3;
    localparam int SEL_W  = 4;

    typedef enum logic [SEL_W-1:0] {
        OP_NOP         = 4'd0,
        OP_ADD16       = 4'd1,
        OP_LDW_IMM     = 4'd2,
        OP_STW_ABS     = 4'd3,
        OP_LDW_ABS     = 4'd4,
        OP_INCW        = 4'd5,
        OP_DECW        = 4'd6,
        OP_INCB        = 4'd7,
        OP_DECB        = 4'd8,
        OP_LDB_IMM     = 4'd9,
        OP_BIT_HANDOFF = 4'd10
    } op_class_e;

    typedef enum logic [SEL_W-1:0] {
        SEL_NONE     = 4'd0,
        SEL_BC       = 4'd1,
        SEL_DE       = 4'd2,
        SEL_SP       = 4'd3,
        SEL_IDX      = 4'd4,
        SEL_IDX_HI   = 4'd5,
        SEL_IDX_LO   = 4'd6,
        SEL_MEM_DISP = 4'd7,
        SEL_MEM_ABS  = 4'd8,
        SEL_IMM8     = 4'd9,
        SEL_IMM16    = 4'd10
    } sel_e;

    typedef enum logic [2:0] {
        ST_PREFIX = 3'd0,
        ST_OPCODE = 3'd1,
        ST_DISP   = 3'd2,
        ST_IMM_LO = 3'd3,
        ST_IMM_HI = 3'd4
    } seq_state_e;

    typedef struct packed {
        op_class_e        op;
        sel_e             dst;
        sel_e             src;
        logic             need_disp;
        logic [1:0]       imm_cnt;
        logic [LEN_W-1:0] len;
    } op_info_t;
endpackage

// File: rtl/idx_opcode_classify.sv
// Combinational table for the opcode that follows an index prefix.
// Output: operation class, selectors, the extra bytes the opcode needs,
// and the total length. Assumes the prefix and opcode are always two bytes.
module idx_opcode_classify
    import idx_dec_pkg::*;
#(
    parameter logic [BYTE_W-1:0] ESC_CODE = 8'hCB
) (
    input  logic [BYTE_W-1:0] opcode,
    output op_info_t          info
);
    logic [1:0] f_x;
    logic [1:0] f_p;
    logic [2:0] f_z;
    logic       f_q;
    sel_e       half_sel;
    sel_e       pair_sel;

    // Split the opcode into its fields.
    always_comb begin
        f_x = opcode[7:6];
        f_p = opcode[5:4];
        f_z = opcode[2:0];
        f_q = opcode[3];
    end

    // Half-register and register-pair selections used by several rows.
    always_comb begin
        half_sel = f_q ? SEL_IDX_LO : SEL_IDX_HI;
        case (f_p)
            2'd0:    pair_sel = SEL_BC;
            2'd1:    pair_sel = SEL_DE;
            2'd2:    pair_sel = SEL_IDX;
            default: pair_sel = SEL_SP;
        endcase
    end

    // Decode table; anything unmatched stays a no-operation.
    always_comb begin
        info.op        = OP_NOP;
        info.dst       = SEL_NONE;
        info.src       = SEL_NONE;
        info.need_disp = 1'b0;
        info.imm_cnt   = 2'd0;
        if (opcode == ESC_CODE) begin
            info.op = OP_BIT_HANDOFF;
        end else if (f_x == 2'd0 && opcode[3:0] == 4'h9) begin
            info.op  = OP_ADD16;
            info.dst = SEL_IDX;
            info.src = pair_sel;
        end else if (f_x == 2'd0 && f_p == 2'd2) begin
            case (f_z)
                3'd1: begin
                    info.op      = OP_LDW_IMM;
                    info.dst     = SEL_IDX;
                    info.src     = SEL_IMM16;
                    info.imm_cnt = 2'd2;
                end
                3'd2: begin
                    info.op      = f_q ? OP_LDW_ABS : OP_STW_ABS;
                    info.dst     = f_q ? SEL_IDX : SEL_MEM_ABS;
                    info.src     = f_q ? SEL_MEM_ABS : SEL_IDX;
                    info.imm_cnt = 2'd2;
                end
                3'd3: begin
                    info.op  = f_q ? OP_DECW : OP_INCW;
                    info.dst = SEL_IDX;
                end
                3'd4: begin
                    info.op  = OP_INCB;
                    info.dst = half_sel;
                end
                3'd5: begin
                    info.op  = OP_DECB;
                    info.dst = half_sel;
                end
                3'd6: begin
                    info.op      = OP_LDB_IMM;
                    info.dst     = half_sel;
                    info.src     = SEL_IMM8;
                    info.imm_cnt = 2'd1;
                end
                default: info.op = OP_NOP;
            endcase
        end else if (f_x == 2'd0 && f_p == 2'd3 && (f_z == 3'd4 || f_z == 3'd5 || f_z == 3'd6) && !f_q) begin
            info.dst       = SEL_MEM_DISP;
            info.need_disp = 1'b1;
            case (f_z)
                3'd4:    info.op = OP_INCB;
                3'd5:    info.op = OP_DECB;
                default: begin
                    info.op      = OP_LDB_IMM;
                    info.src     = SEL_IMM8;
                    info.imm_cnt = 2'd1;
                end
            endcase
        end
        info.len = LEN_W'(2) + LEN_W'(info.need_disp) + LEN_W'(info.imm_cnt);
    end
endmodule

// File: rtl/idx_byte_sequencer.sv
// Byte-collection state machine: waits for a prefix, takes the opcode,
// then the displacement and immediate bytes the opcode calls for.
// Assumes the opcode's needs are reported combinationally every cycle.
module idx_byte_sequencer
    import idx_dec_pkg::*;
#(
    parameter logic [BYTE_W-1:0] PFX_X = 8'hDD,
    parameter logic [BYTE_W-1:0] PFX_Y = 8'hFD
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fire,
    input  logic [BYTE_W-1:0] byte_in,
    input  logic              need_disp,
    input  logic [1:0]        imm_cnt,
    output seq_state_e        state,
    output logic              idx_sel,
    output logic              ready,
    output logic              finish,
    output logic [LEN_W-1:0]  cnt
);
    seq_state_e nxt;
    logic       is_pfx;

    // Recognise either prefix byte.
    always_comb is_pfx = (byte_in == PFX_X) || (byte_in == PFX_Y);

    // Next state and the end-of-instruction strobe.
    always_comb begin
        nxt    = state;
        finish = 1'b0;
        if (fire) begin
            case (state)
                ST_PREFIX: if (is_pfx) nxt = ST_OPCODE;
                ST_OPCODE: begin
                    if (need_disp)          nxt = ST_DISP;
                    else if (imm_cnt != 0)  nxt = ST_IMM_LO;
                    else begin
                        nxt    = ST_PREFIX;
                        finish = 1'b1;
                    end
                end
                ST_DISP: begin
                    if (imm_cnt != 0) nxt = ST_IMM_LO;
                    else begin
                        nxt    = ST_PREFIX;
                        finish = 1'b1;
                    end
                end
                ST_IMM_LO: begin
                    if (imm_cnt == 2'd2) nxt = ST_IMM_HI;
                    else begin
                        nxt    = ST_PREFIX;
                        finish = 1'b1;
                    end
                end
                ST_IMM_HI: begin
                    nxt    = ST_PREFIX;
                    finish = 1'b1;
                end
                default: nxt = ST_PREFIX;
            endcase
        end
    end

    // State, index choice, ready flag and consumed-byte counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_PREFIX;
            idx_sel <= 1'b0;
            ready   <= 1'b0;
            cnt     <= '0;
        end else begin
            state <= nxt;
            ready <= 1'b1;
            if (fire && state == ST_PREFIX && is_pfx) begin
                idx_sel <= (byte_in == PFX_Y);
                cnt     <= LEN_W'(1);
            end else if (fire && state != ST_PREFIX) begin
                cnt <= cnt + LEN_W'(1);
            end
        end
    end

    // The end strobe never repeats in the next cycle.
    p_single_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
        finish |=> !finish);
endmodule

// File: rtl/idx_record_builder.sv
// Captures the displacement and low immediate byte, then registers the
// complete record on the final byte. Assumes the final byte is always
// the last immediate byte when the opcode takes one.
module idx_record_builder
    import idx_dec_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fire,
    input  logic              finish,
    input  logic [BYTE_W-1:0] byte_in,
    input  seq_state_e        state,
    input  logic              idx_sel,
    input  op_info_t          info,
    output logic              out_valid,
    output logic              out_idx,
    output logic [SEL_W-1:0]  out_op,
    output logic [SEL_W-1:0]  out_dst,
    output logic [SEL_W-1:0]  out_src,
    output logic [WORD_W-1:0] out_disp,
    output logic [WORD_W-1:0] out_imm,
    output logic [LEN_W-1:0]  out_len
);
    localparam int EXT_W = WORD_W - BYTE_W;

    logic [BYTE_W-1:0] disp_q;
    logic [BYTE_W-1:0] lo_q;
    logic [BYTE_W-1:0] disp_byte;
    logic [WORD_W-1:0] disp_ext;
    logic [WORD_W-1:0] imm_val;

    // Hold the displacement and first immediate byte as they pass.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            disp_q <= '0;
            lo_q   <= '0;
        end else begin
            if (fire && state == ST_DISP)   disp_q <= byte_in;
            if (fire && state == ST_IMM_LO) lo_q   <= byte_in;
        end
    end

    // Sign-extend the displacement; zero when the opcode has none.
    always_comb begin
        disp_byte = (state == ST_DISP) ? byte_in : disp_q;
        disp_ext  = info.need_disp ? {{EXT_W{disp_byte[BYTE_W-1]}}, disp_byte} : '0;
    end

    // Assemble the immediate from the final byte and the saved low byte.
    always_comb begin
        case (info.imm_cnt)
            2'd1:    imm_val = {{EXT_W{1'b0}}, byte_in};
            2'd2:    imm_val = {byte_in, lo_q};
            default: imm_val = '0;
        endcase
    end

    // Register the record and the one-cycle valid pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_idx   <= 1'b0;
            out_op    <= '0;
            out_dst   <= '0;
            out_src   <= '0;
            out_disp  <= '0;
            out_imm   <= '0;
            out_len   <= '0;
        end else begin
            out_valid <= finish;
            if (finish) begin
                out_idx  <= idx_sel;
                out_op   <= info.op;
                out_dst  <= info.dst;
                out_src  <= info.src;
                out_disp <= disp_ext;
                out_imm  <= imm_val;
                out_len  <= info.len;
            end
        end
    end

    // Memory forms carry a properly sign-extended displacement.
    p_disp_sext_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_dst == SEL_MEM_DISP) |-> (out_disp[WORD_W-1:BYTE_W] == {EXT_W{out_disp[BYTE_W-1]}}));

    // Records without a displacement report zero.
    p_disp_unused_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_dst != SEL_MEM_DISP) |-> (out_disp == '0));

    // A hand-off record covers only the prefix and the escape byte.
    p_handoff_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_op == OP_BIT_HANDOFF) |-> (out_len == LEN_W'(2)));
endmodule

// File: rtl/idx_prefix_decoder.sv
// Top of the index-prefix decoder. Takes a byte stream that starts with a
// prefix, classifies the opcode and emits one record per instruction.
// Assumes the downstream consumer samples the record on the valid pulse.
module idx_prefix_decoder
    import idx_dec_pkg::*;
#(
    parameter logic [7:0] PFX_X    = 8'hDD,
    parameter logic [7:0] PFX_Y    = 8'hFD,
    parameter logic [7:0] ESC_CODE = 8'hCB
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic [7:0]  in_byte,
    output logic        in_ready,
    output logic        out_valid,
    output logic        out_idx,
    output logic [3:0]  out_op,
    output logic [3:0]  out_dst,
    output logic [3:0]  out_src,
    output logic [15:0] out_disp,
    output logic [15:0] out_imm,
    output logic [2:0]  out_len
);
    logic              fire;
    logic              seq_finish;
    logic              seq_idx;
    logic [LEN_W-1:0]  seq_cnt;
    seq_state_e        seq_state;
    logic [BYTE_W-1:0] op_q;
    logic [BYTE_W-1:0] cls_opcode;
    op_info_t          info;

    // A byte moves when offered and accepted.
    always_comb fire = in_valid && in_ready;

    // Keep the opcode so the table stays valid for the trailing bytes.
    always_ff @(posedge clk) begin
        if (!rst_n)                           op_q <= '0;
        else if (fire && seq_state == ST_OPCODE) op_q <= in_byte;
    end

    // The table sees the live byte in the opcode slot, the saved one later.
    always_comb cls_opcode = (seq_state == ST_OPCODE) ? in_byte : op_q;

    idx_opcode_classify #(.ESC_CODE(ESC_CODE)) u_classify (
        .opcode (cls_opcode),
        .info   (info)
    );

    idx_byte_sequencer #(.PFX_X(PFX_X), .PFX_Y(PFX_Y)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .fire      (fire),
        .byte_in   (in_byte),
        .need_disp (info.need_disp),
        .imm_cnt   (info.imm_cnt),
        .state     (seq_state),
        .idx_sel   (seq_idx),
        .ready     (in_ready),
        .finish    (seq_finish),
        .cnt       (seq_cnt)
    );

    idx_record_builder u_build (
        .clk       (clk),
        .rst_n     (rst_n),
        .fire      (fire),
        .finish    (seq_finish),
        .byte_in   (in_byte),
        .state     (seq_state),
        .idx_sel   (seq_idx),
        .info      (info),
        .out_valid (out_valid),
        .out_idx   (out_idx),
        .out_op    (out_op),
        .out_dst   (out_dst),
        .out_src   (out_src),
        .out_disp  (out_disp),
        .out_imm   (out_imm),
        .out_len   (out_len)
    );

    // The counted bytes agree with the length the table reports.
    p_len_matches_count_r13: assert property (@(posedge clk) disable iff (!rst_n)
        seq_finish |-> (LEN_W'(seq_cnt + LEN_W'(1)) == info.len));

    // A non-prefix byte at instruction start yields nothing.
    p_stray_dropped_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && seq_state == ST_PREFIX && in_byte != PFX_X && in_byte != PFX_Y)
        |=> (!out_valid && seq_state == ST_PREFIX));

    // Ready is raised once reset is released.
    p_ready_after_reset_r12: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> in_ready);
endmodule

// File: tb/tb_idx_prefix_decoder.sv
// Directed bench for the index-prefix decoder; one task per scenario.
module tb_idx_prefix_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_byte = 8'h00;
    logic        in_ready;
    logic        out_valid;
    logic        out_idx;
    logic [3:0]  out_op;
    logic [3:0]  out_dst;
    logic [3:0]  out_src;
    logic [15:0] out_disp;
    logic [15:0] out_imm;
    logic [2:0]  out_len;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    idx_prefix_decoder dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
        .in_ready(in_ready), .out_valid(out_valid), .out_idx(out_idx),
        .out_op(out_op), .out_dst(out_dst), .out_src(out_src),
        .out_disp(out_disp), .out_imm(out_imm), .out_len(out_len)
    );

    task automatic chk(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Offer one byte at a falling edge; return at the next falling edge.
    task automatic put(input logic [7:0] b);
        in_valid = 1'b1;
        in_byte  = b;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic check_rec(input string tag, input logic idx, input logic [3:0] op,
                             input logic [3:0] dst, input logic [3:0] src,
                             input logic [15:0] disp, input logic [15:0] imm, input logic [2:0] len);
        chk(tag, "valid", {15'd0, out_valid}, 16'd1);
        chk(tag, "idx", {15'd0, out_idx}, {15'd0, idx});
        chk(tag, "op", {12'd0, out_op}, {12'd0, op});
        chk(tag, "dst", {12'd0, out_dst}, {12'd0, dst});
        chk(tag, "src", {12'd0, out_src}, {12'd0, src});
        chk(tag, "disp", out_disp, disp);
        chk(tag, "imm", out_imm, imm);
        chk({tag, "/R13"}, "len", {13'd0, out_len}, {13'd0, len});
    endtask

    task automatic t_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R12", "in_ready in reset", {15'd0, in_ready}, 16'd0);
        chk("R12", "out_valid in reset", {15'd0, out_valid}, 16'd0);
        chk("R12", "out_op in reset", {12'd0, out_op}, 16'd0);
        chk("R12", "out_imm in reset", out_imm, 16'd0);
        rst_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk("R12", "in_ready after reset", {15'd0, in_ready}, 16'd1);
    endtask

    task automatic t_add16();
        put(8'hDD); put(8'h09); check_rec("R3", 0, 1, 4, 1, 0, 0, 2);
        put(8'hFD); put(8'h19); check_rec("R3", 1, 1, 4, 2, 0, 0, 2);
        put(8'hDD); put(8'h29); check_rec("R3", 0, 1, 4, 4, 0, 0, 2);
        put(8'hFD); put(8'h39); check_rec("R3", 1, 1, 4, 3, 0, 0, 2);
    endtask

    task automatic t_word_imm();
        put(8'hFD); put(8'h21); put(8'h34);
        chk("R11", "no early valid", {15'd0, out_valid}, 16'd0);
        put(8'h12);
        check_rec("R4", 1, 2, 4, 10, 0, 16'h1234, 4);
    endtask

    task automatic t_abs();
        put(8'hDD); put(8'h22); put(8'hCD); put(8'hAB);
        check_rec("R5", 0, 3, 8, 4, 0, 16'hABCD, 4);
        put(8'hFD); put(8'h2A); put(8'h00); put(8'h80);
        check_rec("R5", 1, 4, 4, 8, 0, 16'h8000, 4);
    endtask

    task automatic t_incdec_word();
        put(8'hDD); put(8'h23); check_rec("R6", 0, 5, 4, 0, 0, 0, 2);
        put(8'hFD); put(8'h2B); check_rec("R6", 1, 6, 4, 0, 0, 0, 2);
    endtask

    task automatic t_halves();
        put(8'hDD); put(8'h24); check_rec("R7", 0, 7, 5, 0, 0, 0, 2);
        put(8'hFD); put(8'h2D); check_rec("R7", 1, 8, 6, 0, 0, 0, 2);
        put(8'hDD); put(8'h26); put(8'h5A); check_rec("R7", 0, 9, 5, 9, 0, 16'h005A, 3);
        put(8'hFD); put(8'h2E); put(8'hA5); check_rec("R7", 1, 9, 6, 9, 0, 16'h00A5, 3);
    endtask

    task automatic t_mem_disp();
        put(8'hDD); put(8'h34); put(8'h7F); check_rec("R8", 0, 7, 7, 0, 16'h007F, 0, 3);
        put(8'hFD); put(8'h35); put(8'h80); check_rec("R8", 1, 8, 7, 0, 16'hFF80, 0, 3);
        put(8'hDD); put(8'h36); put(8'hFE); put(8'h99);
        check_rec("R8", 0, 9, 7, 9, 16'hFFFE, 16'h0099, 4);
    endtask

    task automatic t_unused_cleared();
        put(8'hFD); put(8'h36); put(8'h81); put(8'h77);
        check_rec("R8", 1, 9, 7, 9, 16'hFF81, 16'h0077, 4);
        put(8'hDD); put(8'h2B);
        chk("R10", "disp cleared", out_disp, 16'h0000);
        chk("R10", "imm cleared", out_imm, 16'h0000);
    endtask

    task automatic t_nop();
        put(8'hDD); put(8'h00); check_rec("R9", 0, 0, 0, 0, 0, 0, 2);
        put(8'hFD); put(8'h40); check_rec("R9", 1, 0, 0, 0, 0, 0, 2);
        put(8'hDD); put(8'h27); check_rec("R9", 0, 0, 0, 0, 0, 0, 2);
        put(8'hFD); put(8'h3C); check_rec("R9", 1, 0, 0, 0, 0, 0, 2);
    endtask

    task automatic t_handoff();
        put(8'hFD); put(8'hCB); check_rec("R2", 1, 10, 0, 0, 0, 0, 2);
        put(8'hDD); put(8'h23); check_rec("R2", 0, 5, 4, 0, 0, 0, 2);
    endtask

    task automatic t_stray();
        put(8'h3E);
        chk("R1", "stray gives no record", {15'd0, out_valid}, 16'd0);
        put(8'h21);
        chk("R1", "second stray no record", {15'd0, out_valid}, 16'd0);
        put(8'hDD); put(8'h23); check_rec("R1", 0, 5, 4, 0, 0, 0, 2);
    endtask

    task automatic t_pulse_hold();
        put(8'hFD); put(8'h26); put(8'h3C);
        check_rec("R11", 1, 9, 5, 9, 0, 16'h003C, 3);
        @(negedge clk);
        chk("R11", "valid drops", {15'd0, out_valid}, 16'd0);
        chk("R11", "op held", {12'd0, out_op}, 16'd9);
        chk("R11", "imm held", out_imm, 16'h003C);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_add16();
        t_word_imm();
        t_abs();
        t_incdec_word();
        t_halves();
        t_mem_disp();
        t_unused_cleared();
        t_nop();
        t_handoff();
        t_stray();
        t_pulse_hold();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule